// File: doc/BRIEF.md
# Legacy I/O Window Decoder

This block sits beside a host bus target and decides, for every I/O cycle presented to it, whether the address falls inside one of four legacy device windows. The four windows are a 4-byte FM synthesizer window, a 16-byte sound DSP window, a 2-byte MIDI UART window and a 1-byte game-port window. It returns a one-hot select naming the window that was hit and the byte offset inside that window. It also raises a claim signal, which the bus target logic uses to accept the cycle.

A control register gates the decode. It holds one enable per window, a master switch that turns the whole legacy space off, and a mode bit. The mode bit selects either full 16-bit compare or ISA-style aliasing, in which only address bits below 10 count. Each window has its own base register. Register writes arrive over a simple write strobe and take effect on the following clock edge. The decode itself is combinational from the registered state.

Top module: `legwin_decode`

## Requirements
- R1: After reset the control word is 0x907F, so the master disable and the 10-bit mode are on and all four enables are set. The base resets are FM 0x0388, DSP 0x0220, MIDI 0x0330 and game 0x0201. With reset state, no cycle is claimed.
- R2: While control bit 15 (master disable) is 1, no window is selected and claim stays 0, whatever the enable bits hold.
- R3: Control bits 0..3 enable FM, DSP, MIDI and game respectively. A window whose enable is 0 is never selected.
- R4: The FM window is 4 bytes long. It hits when the address matches the FM base above bit 1, and offset carries address bits [1:0].
- R5: The DSP, MIDI and game windows are 16, 2 and 1 bytes long, each aligned to its size. The offset is the address bits below the window size, with the upper offset bits 0. Base bits below the window size are ignored.
- R6: When control bit 5 (alias mode) is 1, only address bits [9:lg] are compared, where lg is the log2 of the window size. Address bits [15:10] have no effect.
- R7: When control bit 5 is 0, all address bits [15:lg] are compared.
- R8: When several windows match, the first in the order FM, DSP, MIDI, game wins. `dev_sel` bit 0 is FM, bit 1 is DSP, bit 2 is MIDI and bit 3 is game, and `dev_sel` is always one-hot or zero.
- R9: `claim` is 1 exactly when `dev_sel` is nonzero, and `offset` is 0 whenever nothing is claimed.
- R10: A register write (`wr_sel` 0 is control, 1 FM base, 2 DSP base, 3 MIDI base, 4 game base) changes the decode from the next clock edge onward, not in the cycle of the write. Control bits other than 0..3, 5 and 15 have no effect.
- R11: With `io_valid` low, nothing is selected and claim is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 16 | Write data |
| io_valid | input | 1 | An I/O cycle address is present |
| io_addr | input | 16 | I/O cycle address |
| dev_sel | output | 4 | One-hot window select (FM, DSP, MIDI, game) |
| offset | output | 4 | Byte offset inside the selected window |
| claim | output | 1 | Cycle is claimed by a legacy window |

## Verification
The assertions check these properties on every cycle:
- the select is one-hot or zero;
- a set master disable, a cleared DSP enable or an idle `io_valid` keeps the matching outputs low;
- the offset stays inside the selected window's size, and the FM offset equals the low address bits;
- a write that sets the master disable silences claim from the next cycle.

Some behaviours need the bench's scenarios, because only a reference model of the address compare can show them:
- which window wins when windows overlap;
- that aliasing ignores bits [15:10] in 10-bit mode and respects them in full mode;
- that a write leaves the current cycle's decode untouched.

// File: rtl/legwin_pkg.sv
package legwin_pkg;

    localparam int NUM_WIN = 4;

    localparam int CB_DIS   = 15;
    localparam int CB_ALIAS = 5;

    localparam logic [15:0] CTRL_RST = 16'h907F;

    typedef enum logic [1:0] {
        WIN_FM   = 2'd0,
        WIN_DSP  = 2'd1,
        WIN_MIDI = 2'd2,
        WIN_GAME = 2'd3
    } win_e;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_FM   = 3'd1,
        REG_DSP  = 3'd2,
        REG_MIDI = 3'd3,
        REG_GAME = 3'd4
    } reg_e;

    typedef struct packed {
        logic               dis;
        logic               alias10;
        logic [NUM_WIN-1:0] en;
    } ctrl_t;

    // log2 of each window's byte length
    function automatic int win_lg2(input int idx);
        case (idx)
            0:       return 2;
            1:       return 4;
            2:       return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] base_rst(input int idx);
        case (idx)
            0:       return 16'h0388;
            1:       return 16'h0220;
            2:       return 16'h0330;
            default: return 16'h0201;
        endcase
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [15:0] w);
        ctrl_t c;
        c.dis     = w[CB_DIS];
        c.alias10 = w[CB_ALIAS];
        c.en      = w[NUM_WIN-1:0];
        return c;
    endfunction

endpackage

// File: rtl/legwin_regs.sv
module legwin_regs
    import legwin_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [2:0]                      wr_sel,
    input  logic [ADDR_W-1:0]               wr_data,
    output ctrl_t                           ctrl_o,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]  base_o
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_unpack(CTRL_RST);
        end else if (wr_en && wr_sel == REG_CTRL) begin
            ctrl_q <= ctrl_unpack(wr_data[15:0]);
        end
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_base
        logic [ADDR_W-1:0] base_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q <= ADDR_W'(base_rst(i));
            end else if (wr_en && wr_sel == 3'(i + 1)) begin
                base_q <= wr_data;
            end
        end
        assign base_o[i] = base_q;
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/legwin_match.sv
module legwin_match #(
    parameter int ADDR_W  = 16,
    parameter int ALIAS_W = 10,
    parameter int LG2     = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              alias10,
    output logic              hit
);

    logic [ADDR_W-1:0] cmp_mask;

    always_comb begin
        for (int b = 0; b < ADDR_W; b++) begin
            cmp_mask[b] = (b >= LG2) && (!alias10 || b < ALIAS_W);
        end
    end

    assign hit = (((addr ^ base) & cmp_mask) == '0);

endmodule

// File: rtl/legwin_prio.sv
module legwin_prio
    import legwin_pkg::*;
#(
    parameter int OFS_W = 4
) (
    input  logic [NUM_WIN-1:0] req,
    input  logic [OFS_W-1:0]   addr_lo,
    output logic [NUM_WIN-1:0] sel,
    output logic [OFS_W-1:0]   ofs
);

    logic [NUM_WIN-1:0][OFS_W-1:0] ofs_mask;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_mask
        assign ofs_mask[i] = OFS_W'((1 << win_lg2(i)) - 1);
    end

    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        ofs   = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (req[i] && !found) begin
                found  = 1'b1;
                sel[i] = 1'b1;
                ofs    = addr_lo & ofs_mask[i];
            end
        end
    end

endmodule

// File: rtl/legwin_decode.sv
module legwin_decode
    import legwin_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ALIAS_W = 10,
    parameter int OFS_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              io_valid,
    input  logic [ADDR_W-1:0] io_addr,
    output logic [NUM_WIN-1:0] dev_sel,
    output logic [OFS_W-1:0]  offset,
    output logic              claim
);

    ctrl_t                          ctrl_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
    logic [NUM_WIN-1:0]             hit;
    logic [NUM_WIN-1:0]             req;

    legwin_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl_o  (ctrl_q),
        .base_o  (base_q)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        legwin_match #(
            .ADDR_W  (ADDR_W),
            .ALIAS_W (ALIAS_W),
            .LG2     (win_lg2(i))
        ) u_match (
            .addr    (io_addr),
            .base    (base_q[i]),
            .alias10 (ctrl_q.alias10),
            .hit     (hit[i])
        );
        assign req[i] = io_valid && !ctrl_q.dis && ctrl_q.en[i] && hit[i];
    end

    legwin_prio #(.OFS_W(OFS_W)) u_prio (
        .req     (req),
        .addr_lo (io_addr[OFS_W-1:0]),
        .sel     (dev_sel),
        .ofs     (offset)
    );

    assign claim = |dev_sel;

endmodule

// File: rtl/legwin_decode_chk.sv
module legwin_decode_chk
    import legwin_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [2:0]   wr_sel,
    input logic [15:0]  wr_data,
    input logic         io_valid,
    input logic [15:0]  io_addr,
    input logic [3:0]   dev_sel,
    input logic [3:0]   offset,
    input logic         claim,
    input ctrl_t        ctrl
);

    p_sel_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_sel));

    p_dis_silent_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl.dis |-> (dev_sel == '0));

    p_dsp_gated_r3: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en[WIN_DSP] |-> !dev_sel[WIN_DSP]);

    p_idle_no_claim_r11: assert property (@(posedge clk) disable iff (rst)
        !io_valid |-> !claim);

    p_ofs_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (dev_sel == '0) |-> (offset == '0));

    p_fm_ofs_r4: assert property (@(posedge clk) disable iff (rst)
        dev_sel[WIN_FM] |-> (offset == {2'b00, io_addr[1:0]}));

    p_game_ofs_r5: assert property (@(posedge clk) disable iff (rst)
        dev_sel[WIN_GAME] |-> (offset == '0));

    p_midi_ofs_r5: assert property (@(posedge clk) disable iff (rst)
        dev_sel[WIN_MIDI] |-> (offset < 4'd2));

    p_dis_write_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == REG_CTRL && wr_data[CB_DIS]) |=> !claim);

endmodule

bind legwin_decode legwin_decode_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .io_valid (io_valid),
    .io_addr  (io_addr),
    .dev_sel  (dev_sel),
    .offset   (offset),
    .claim    (claim),
    .ctrl     (ctrl_q)
);

// File: tb/tb_legwin_decode.sv
`timescale 1ns/1ps
module tb_legwin_decode;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        io_valid = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  dev_sel;
    logic [3:0]  offset;
    logic        claim;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [15:0] m_ctrl;
    logic [15:0] m_base [4];

    always #5 clk = ~clk;

    legwin_decode dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .io_valid(io_valid), .io_addr(io_addr),
        .dev_sel(dev_sel), .offset(offset), .claim(claim)
    );

    function automatic int lg_of(input int i);
        case (i)
            0: return 2;
            1: return 4;
            2: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic void model(input logic [15:0] a, input logic v,
                                  output logic [3:0] s, output logic [3:0] o);
        s = '0;
        o = '0;
        if (v && !m_ctrl[15]) begin
            for (int i = 0; i < 4; i++) begin
                if (s == '0 && m_ctrl[i]) begin
                    int hi;
                    logic match;
                    hi = m_ctrl[5] ? 9 : 15;
                    match = 1'b1;
                    for (int b = lg_of(i); b <= hi; b++)
                        if (a[b] != m_base[i][b]) match = 1'b0;
                    if (match) begin
                        s = 4'(1 << i);
                        o = a[3:0] & 4'((1 << lg_of(i)) - 1);
                    end
                end
            end
        end
    endfunction

    task automatic write_reg(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel == 3'd0) m_ctrl = d;
        else if (sel <= 3'd4) m_base[sel - 1] = d;
    endtask

    task automatic check_now(input string tag);
        logic [3:0] es, eo;
        model(io_addr, io_valid, es, eo);
        checks++;
        if (dev_sel !== es || offset !== eo || claim !== (es != 0)) begin
            errors++;
            $display("FAIL %s addr=%h sel=%h/%h ofs=%h/%h claim=%b/%b (actual/expected)",
                     tag, io_addr, dev_sel, es, offset, eo, claim, es != 0);
        end
    endtask

    task automatic probe(input logic [15:0] a, input string tag);
        @(negedge clk);
        io_valid = 1'b1; io_addr = a;
        #1 check_now(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED_1234);
        m_ctrl = 16'h907F;
        m_base[0] = 16'h0388; m_base[1] = 16'h0220;
        m_base[2] = 16'h0330; m_base[3] = 16'h0201;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state disables everything
        probe(16'h0388, "R1 reset FM addr");
        probe(16'h0220, "R1 reset DSP addr");
        // R2: enables alone do not override disable
        write_reg(3'd0, 16'h800F);
        probe(16'h0331, "R2 disable wins");
        // R6: alias mode, R4 FM offset
        write_reg(3'd0, 16'h002F);
        probe(16'h0388, "R1 reset base FM");
        probe(16'h138A, "R6 alias FM ofs 2");
        probe(16'hFE2D, "R6 alias DSP");
        probe(16'h0201, "R5 game");
        probe(16'h0331, "R5 MIDI ofs 1");
        probe(16'h0332, "R5 MIDI miss");
        // R7: full compare
        write_reg(3'd0, 16'h000F);
        probe(16'h138A, "R7 full miss");
        probe(16'h038B, "R4 FM ofs 3");
        // R3: DSP enable cleared
        write_reg(3'd0, 16'h000D);
        probe(16'h0225, "R3 DSP disabled");
        // R8: overlap DSP onto FM, R5 base low bits ignored
        write_reg(3'd0, 16'h000F);
        write_reg(3'd2, 16'h0387);
        probe(16'h0389, "R8 FM beats DSP");
        write_reg(3'd0, 16'h000E);
        probe(16'h0389, "R8 DSP after FM off ofs 9");
        // R11: idle
        @(negedge clk); io_valid = 1'b0; io_addr = 16'h0389;
        #1 check_now("R11 idle");
        // R10: write takes effect next edge
        probe(16'h0201, "R10 before write");
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd4; wr_data = 16'h0208;
        #1 check_now("R10 same cycle old base");
        @(negedge clk);
        wr_en = 1'b0; m_base[3] = 16'h0208;
        #1 check_now("R10 next cycle new base");
        probe(16'h0208, "R10 new game base");
        // R10: reserved control bits have no effect
        write_reg(3'd0, 16'h7FDF);
        probe(16'h0208, "R10 reserved bits");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            if (($urandom % 4) == 0) begin
                logic [2:0] rs;
                logic [15:0] rd;
                rs = 3'($urandom % 5);
                rd = 16'($urandom);
                if (rs == 3'd0 && ($urandom % 4) != 0) rd[15] = 1'b0;
                write_reg(rs, rd);
            end
            begin
                logic [15:0] a;
                int w;
                w = $urandom % 4;
                a = m_base[w] ^ 16'($urandom % 16);
                if (($urandom % 3) == 0) a = a ^ 16'($urandom & 32'hFC00);
                if (($urandom % 8) == 0) a = 16'($urandom);
                @(negedge clk);
                io_valid = (($urandom % 10) != 0);
                io_addr = a;
                #1 check_now("R4 R5 R6 R7 R8 R9 random");
            end
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule